// File: doc/BRIEF.md
# Multi-Core Clock Divider with Smooth Reload

This block derives up to four core clock enables from one parent clock. Each core has a divide ratio, and the core's enable pulses once every ratio-many parent cycles. Software programs the ratios through a small memory-mapped register port. A new ratio does not take effect when it is written. It waits until the core's reload enable is set and a shared update trigger is raised. Even then it is applied only where the core's current output period ends, so no period is ever cut short or stretched.

The usual sequence has four steps. Software writes the ratio register. It then sets the reload enables of the cores it wants to change. Next it raises the trigger bit. Afterwards it clears the enables and the trigger again. Clearing them leaves the ratios in force untouched. Each core's output is a one-cycle clock-enable tick in the parent domain. With ratio 1 this tick is high on every cycle.

Top module: `core_clkdiv_bank`

## Requirements
- R1: After reset every core ticks on every cycle (ratio 1), the control register reads 0x00000000 and the ratio register reads 0x01010101.
- R2: A write at byte offset 0x0 updates the control register and a write at 0xC updates the ratio register. Both read back the full 32-bit value last written. Any other offset reads 0 and writes to it change nothing.
- R3: Core i's ratio is bits [8i+5:8i] of the ratio register; bits 8i+6 and 8i+7 are stored but ignored. Once a ratio N is in force, the core's tick repeats every N cycles, for any N from 1 to 63.
- R4: Each 0-to-1 transition of control bit 24 triggers exactly one load. Holding bit 24 high, or writing it as 1 again while it is already 1, triggers no further load.
- R5: A loaded ratio takes over only at the end of the current output period. Every interval between ticks equals either the old ratio or the new one.
- R6: A ratio field of 0 behaves as ratio 1: the core ticks on every cycle.
- R7: Writing the ratio register without a trigger edge leaves the ratios in force unchanged. Clearing the reload enables or the trigger also leaves them unchanged.
- R8: A trigger edge loads only those cores whose reload enable (control bit 20+i) is set. All other cores keep their ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, sampled on the rising clock edge |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| core_tick | output | NUM_CORES | Per-core clock-enable tick, one cycle wide, once per divided period |

## Verification
The hardest case to reach is a ratio change landing in the middle of a long output period. The bench has to show that the switch waits for the period boundary and never makes an interval that is neither the old ratio nor the new one. A gap monitor runs on every core for the whole test. It accepts the current ratio, or the next ratio queued by the driver, and nothing else. The stimulus moves cores between ratios 1, 2, 3, 4, 5 and 63 with the trigger raised at arbitrary phases. Separate steps hold the trigger high across further writes, so that a missing edge detect would show up as an unexpected interval.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 4;
  localparam int RATIO_W      = 6;
  localparam int FIELD_STRIDE = 8;
  localparam int RELOAD_LSB   = 20;
  localparam int TRIG_BIT     = 24;
  localparam logic [ADDR_W-1:0] CTRL_OFS  = 4'h0;
  localparam logic [ADDR_W-1:0] RATIO_OFS = 4'hC;

  typedef logic [RATIO_W-1:0] ratio_t;

  // A zero field means pass-through.
  function automatic ratio_t eff_ratio(ratio_t raw);
    return (raw == '0) ? ratio_t'(1) : raw;
  endfunction

  // Reset image of the ratio register: ratio 1 in every core field.
  function automatic logic [DATA_W-1:0] ratio_reg_reset(int n);
    logic [DATA_W-1:0] v;
    v = '0;
    for (int i = 0; i < n; i++) v[i*FIELD_STRIDE +: RATIO_W] = ratio_t'(1);
    return v;
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic [NUM_CORES-1:0]          reload_en_o,
  output logic                          trig_o,
  output ratio_t [NUM_CORES-1:0]        field_o
);
  localparam logic [DATA_W-1:0] RATIO_RST = ratio_reg_reset(NUM_CORES);

  logic [DATA_W-1:0] ctrl_q, ratio_q;
  logic              ctrl_wr, ratio_wr;

  assign ctrl_wr  = wr_i && (addr_i == CTRL_OFS);
  assign ratio_wr = wr_i && (addr_i == RATIO_OFS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ratio_q <= RATIO_RST;
    end else begin
      if (ctrl_wr)  ctrl_q  <= wdata_i;
      if (ratio_wr) ratio_q <= wdata_i;
    end
  end

  always_comb begin
    if (addr_i == CTRL_OFS)       rdata_o = ctrl_q;
    else if (addr_i == RATIO_OFS) rdata_o = ratio_q;
    else                          rdata_o = '0;
  end

  assign reload_en_o = ctrl_q[RELOAD_LSB +: NUM_CORES];
  assign trig_o      = ctrl_q[TRIG_BIT];

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_field
    assign field_o[i] = ratio_q[i*FIELD_STRIDE +: RATIO_W];
  end

  // R2: a write to an unmapped offset leaves both registers as they were
  a_r2_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !ratio_wr) |=> ($stable(ctrl_q) && $stable(ratio_q)));
endmodule

// File: rtl/clkdiv_reload.sv
module clkdiv_reload
  import clkdiv_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig_i,
  input  logic [NUM_CORES-1:0]   reload_en_i,
  input  ratio_t [NUM_CORES-1:0] field_i,
  output logic [NUM_CORES-1:0]   load_o,
  output ratio_t [NUM_CORES-1:0] load_ratio_o
);
  logic trig_d;
  logic trig_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_d <= 1'b0;
    else        trig_d <= trig_i;
  end

  assign trig_rise = trig_i && !trig_d;
  assign load_o    = {NUM_CORES{trig_rise}} & reload_en_i;

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_ratio
    assign load_ratio_o[i] = eff_ratio(field_i[i]);
  end

  // R4: one trigger edge yields a single load cycle, never two in a row
  a_r4_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_o) |=> !(|load_o));

  // R8: a core without reload enable is never loaded
  a_r8_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_o & ~reload_en_i) && ((load_o & ~reload_en_i) == '0));
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_i,
  input  ratio_t load_ratio_i,
  output logic   tick_o
);
  ratio_t cnt_q, active_q, pend_q;
  logic   pend_v;
  logic   adopt;

  assign tick_o = (cnt_q == active_q - ratio_t'(1));
  assign adopt  = tick_o && pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= ratio_t'(1);
      pend_v <= 1'b0;
    end else if (load_i) begin
      pend_q <= load_ratio_i;
      pend_v <= 1'b1;
    end else if (adopt) begin
      pend_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= ratio_t'(1);
    end else if (tick_o) begin
      cnt_q <= '0;
      if (pend_v) active_q <= pend_q;
    end else begin
      cnt_q <= cnt_q + ratio_t'(1);
    end
  end

  // R3: the phase counter stays inside the period of the ratio in force
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < active_q);

  // R5: the ratio in force changes only on a period boundary
  a_r5_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_q) |-> $past(tick_o));

  // R5: a pending ratio is taken over at the next boundary
  a_r5_adopt_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && tick_o && !load_i) |=> (!pend_v && active_q == $past(pend_q)));

  // R7: with nothing pending the ratio in force holds
  a_r7_hold_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_v |=> $stable(active_q));
endmodule

// File: rtl/core_clkdiv_bank.sv
module core_clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [3:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CORES-1:0] core_tick
);
  logic [NUM_CORES-1:0]   reload_en;
  logic                   trig;
  ratio_t [NUM_CORES-1:0] field;
  logic [NUM_CORES-1:0]   load;
  ratio_t [NUM_CORES-1:0] load_ratio;

  clkdiv_regs #(.NUM_CORES(NUM_CORES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .reload_en_o(reload_en),
    .trig_o(trig), .field_o(field)
  );

  clkdiv_reload #(.NUM_CORES(NUM_CORES)) u_reload (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .reload_en_i(reload_en),
    .field_i(field), .load_o(load), .load_ratio_o(load_ratio)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    clkdiv_core u_core (
      .clk(clk), .rst_n(rst_n), .load_i(load[i]),
      .load_ratio_i(load_ratio[i]), .tick_o(core_tick[i])
    );
  end
endmodule

// File: tb/test_core_clkdiv_bank.sv
module test_core_clkdiv_bank;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] core_tick;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit mon_on = 1'b0;

  int unsigned exp_q[NC][$];
  int unsigned exp_cur[NC];
  int unsigned last_req[NC];
  int unsigned since[NC];

  always #2.5 clk = ~clk;

  core_clkdiv_bank #(.NUM_CORES(NC)) i_core_clkdiv_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_tick(core_tick)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Driver side of the scoreboard: queue the ratio a core must move to.
  task automatic expect_ratio(input int k, input int unsigned r);
    if (r != last_req[k]) begin
      exp_q[k].push_back(r);
      last_req[k] = r;
    end
  endtask

  task automatic measure_gap(input int k, input string req, input int unsigned exp);
    int unsigned n;
    @(negedge clk);
    while (!core_tick[k]) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!core_tick[k] && n < 200);
    check(req, n, exp);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor side: every tick interval must match the ratio in force or the next queued one.
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      for (int k = 0; k < NC; k++) begin
        if (core_tick[k]) begin
          n_checks++;
          if ((since[k] + 1) != exp_cur[k]) begin
            if (exp_q[k].size() > 0 && (since[k] + 1) == exp_q[k][0]) begin
              exp_cur[k] = exp_q[k].pop_front();
            end else begin
              n_errors++;
              $display("FAIL R5 core%0d interval: actual=%0d expected=%0d", k, since[k] + 1, exp_cur[k]);
            end
          end
          since[k] = 0;
        end else begin
          since[k] = since[k] + 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic drain_check(input string req);
    for (int k = 0; k < NC; k++) check(req, exp_q[k].size(), 0);
  endtask

  initial begin
    logic [31:0] rd;
    for (int k = 0; k < NC; k++) begin
      exp_cur[k] = 1; last_req[k] = 1; since[k] = 0;
    end
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(1);

    // R1: reset image and ratio-1 ticking
    reg_read(4'h0, rd); check("R1 ctrl reset", rd, 32'h0);
    reg_read(4'hC, rd); check("R1 ratio reset", rd, 32'h0101_0101);
    check("R1 ticks every cycle", core_tick, 4'hF);
    wait_cycles(1);
    check("R1 ticks every cycle", core_tick, 4'hF);
    mon_on = 1'b1;

    // R7: ratios written without any trigger stay dormant
    reg_write(4'hC, 32'h0500_0302);
    reg_read(4'hC, rd); check("R2 ratio readback", rd, 32'h0500_0302);
    wait_cycles(20);
    measure_gap(0, "R7 no trigger core0", 1);
    measure_gap(3, "R7 no trigger core3", 1);

    // R4/R8: trigger edge with cores 0,1,3 enabled; core2 left out
    expect_ratio(0, 2); expect_ratio(1, 3); expect_ratio(3, 5);
    reg_write(4'h0, (32'h1 << 24) | (32'hB << 20));
    wait_cycles(40);
    drain_check("R4 load applied");
    measure_gap(0, "R3 core0 ratio 2", 2);
    measure_gap(1, "R3 core1 ratio 3", 3);
    measure_gap(2, "R8 core2 not enabled", 1);
    measure_gap(3, "R3 core3 ratio 5", 5);

    // R7: clearing enables and trigger keeps ratios
    reg_write(4'h0, 32'h0);
    reg_read(4'h0, rd); check("R2 ctrl readback", rd, 32'h0);
    wait_cycles(30);
    measure_gap(3, "R7 after clear core3", 5);

    // R4: trigger held high across a second write gives no new load
    reg_write(4'hC, 32'h0000_0744);
    reg_write(4'h0, 32'h1 << 24);
    reg_write(4'h0, (32'h1 << 24) | (32'h9 << 20));
    wait_cycles(30);
    measure_gap(0, "R4 held trigger core0", 2);
    measure_gap(3, "R4 held trigger core3", 5);

    // R6/R3: fresh edge; core0 field 0x44 -> 4, core3 field 0 -> 1, core1 not enabled
    reg_write(4'h0, 32'h9 << 20);
    expect_ratio(0, 4); expect_ratio(3, 1);
    reg_write(4'h0, (32'h1 << 24) | (32'h9 << 20));
    wait_cycles(40);
    drain_check("R5 switch completed");
    measure_gap(0, "R3 upper field bits ignored", 4);
    measure_gap(3, "R6 zero ratio passes through", 1);
    measure_gap(1, "R8 core1 keeps ratio", 3);

    // R2: unmapped offset
    reg_write(4'h4, 32'hDEAD_BEEF);
    reg_read(4'h4, rd); check("R2 unmapped reads 0", rd, 32'h0);
    reg_read(4'hC, rd); check("R2 ratio untouched", rd, 32'h0000_0744);
    reg_read(4'h0, rd); check("R2 ctrl untouched", rd, (32'h1 << 24) | (32'h9 << 20));

    // R3: maximum ratio 63 on core1, triggered mid-period
    reg_write(4'hC, 32'h0000_3F44);
    reg_write(4'h0, 32'h0);
    expect_ratio(1, 63);
    reg_write(4'h0, (32'h1 << 24) | (32'h2 << 20));
    wait_cycles(140);
    drain_check("R5 long ratio switch");
    measure_gap(1, "R3 core1 ratio 63", 63);
    measure_gap(0, "R8 core0 unchanged", 4);

    mon_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule